// File: doc/BRIEF.md
# Multiplexed Dot-Matrix LCD Scan Sequencer

This block drives the scan of a passive dot-matrix LCD panel. It owns 80 output pins and, for each pin, produces a 3-bit code that selects one of six analog drive levels. The analog level buffers then apply that level to the glass. Two mode pins choose the duty, and a master/slave pin chooses how the 80 pins are split between the segment (column) and common (row) roles. A master splits the pins into segments and commons. A slave uses all 80 pins as segments, so that it can widen a panel driven by a master.

The row period comes from one of two sources. A master divides its own clock to make a one-cycle row strobe and sends that strobe out on `load_o`. A slave ignores its own divider and steps one row on each rising edge of the strobe it receives on `load_i`. During each row period the block reads the segment bits of the next common row from a synchronous RAM read port, one nibble per cycle, and holds them in a shadow latch. On the next strobe it moves the shadow latch, the row index and the frame polarity to the outputs in one step. The polarity alternates after the last common row of every frame, so that the panel sees no net DC.

Top module: `lcd_scan_sequencer`

## Requirements
- R1: Out of reset the block shows common row 1 in a positive frame with every segment unlit, and `load_o` is low. In master mode 0, pins 1–16 read code 2 (V3), pin 17 reads code 0 (V1) and pins 18–80 read code 4 (V5).
- R2: A master splits its pins by `mode_i`. Mode 0 gives 16 segments and 64 commons. Mode 1 gives 0 segments and 80 commons. Mode 2 gives 32 segments and 48 commons. Mode 3 gives 48 segments and 32 commons. The segments are always the lowest-numbered pins. A slave uses all 80 pins as segments. `bias_o` reads 2 (1/9) for modes 0 and 1, 1 (1/7) for mode 2 and 0 (1/5) for mode 3. The common count of each mode sets the frame length in both roles.
- R3: A master that is not in standby pulses `load_o` high for exactly one clock cycle once every ROW_PERIOD (default 32) cycles.
- R4: A slave keeps `load_o` low. It advances exactly one row per rising edge of `load_i`, however long `load_i` stays high.
- R5: Common row r (0-based) is fetched from addresses r*32+k, for k = 0..19. Bit b of nibble k drives segment 4k+b (0-based pin index).
- R6: Pin codes are 0=V1, 1=V2, 2=V3, 3=V4, 4=V5, 5=GND. Pin p has code field `level_o[3p+2:3p]`. In a positive frame, the selected common is V1, the other commons are V5, lit segments are GND and unlit segments are V3.
- R7: In a negative frame (`frame_neg_o`=1), the selected common is GND, the other commons are V2, lit segments are V1 and unlit segments are V4.
- R8: After the last common row of the mode is shown, the next strobe shows row 1 again and inverts the frame polarity. Polarity changes only on a strobe.
- R9: `level_o` changes only in the cycle after a strobe, and then all pins change together. In the cycle while the strobe is high, the previous row is still shown.
- R10: While `standby_i` is high, no strobe occurs, `load_o` stays low and `level_o` holds its value. A master resumes strobing within ROW_PERIOD cycles of release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | High stops scanning and strobe generation |
| is_master_i | input | 1 | 1 = master (own strobe, mixed pins), 0 = slave |
| mode_i | input | 2 | Duty / pin-split select |
| load_i | input | 1 | Row strobe from a master (used by a slave) |
| load_o | output | 1 | Row strobe driven by a master |
| ram_rd_o | output | 1 | RAM read request |
| ram_addr_o | output | 12 | RAM nibble address |
| ram_data_i | input | 4 | RAM read data, valid the cycle after the request |
| level_o | output | 240 | Per-pin 3-bit drive-level codes, pin 1 in bits 2:0 |
| frame_neg_o | output | 1 | 1 while a negative frame is shown |
| bias_o | output | 2 | Bias select: 0=1/5, 1=1/7, 2=1/9 |

## Verification
The RAM model returns a nibble that is a scrambled function of the address. A wrong row stride, a wrong nibble index or a reversed bit order inside a nibble therefore shows up as a mismatched pin. A master in mode 3 is scanned past one full frame. This separates a correct wrap and polarity flip at 32 rows from an early or late one, and checks the positive and negative code sets on both segment and common pins. A master in mode 2, each mode taken straight out of reset, a slave fed with long-held strobes, and a standby interval in the middle of a scan then separate the pin split, the bias, edge-versus-level strobe handling and the freezing of the scan.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int NUM_PINS = 80;
    localparam int LVL_W    = 3;

    typedef enum logic [LVL_W-1:0] {
        LV_V1  = 3'd0,
        LV_V2  = 3'd1,
        LV_V3  = 3'd2,
        LV_V4  = 3'd3,
        LV_V5  = 3'd4,
        LV_GND = 3'd5
    } lvl_e;

    typedef enum logic [1:0] {
        BIAS_1_5 = 2'd0,
        BIAS_1_7 = 2'd1,
        BIAS_1_9 = 2'd2
    } bias_e;

    function automatic int com_rows(logic [1:0] mode);
        case (mode)
            2'd0:    return 64;
            2'd1:    return 80;
            2'd2:    return 48;
            default: return 32;
        endcase
    endfunction

    function automatic int seg_pins(logic master, logic [1:0] mode);
        if (!master) return NUM_PINS;
        case (mode)
            2'd0:    return 16;
            2'd1:    return 0;
            2'd2:    return 32;
            default: return 48;
        endcase
    endfunction

    function automatic bias_e bias_of(logic [1:0] mode);
        case (mode)
            2'd2:    return BIAS_1_7;
            2'd3:    return BIAS_1_5;
            default: return BIAS_1_9;
        endcase
    endfunction

endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
    parameter int ROW_PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic is_master_i,
    input  logic load_i,
    output logic tick_o,
    output logic load_o
);
    localparam int CNT_W = (ROW_PERIOD > 1) ? $clog2(ROW_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             load_prev;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d           = tmr_q;
        tmr_d.pulse     = 1'b0;
        tmr_d.load_prev = load_i;
        if (!standby_i) begin
            if (is_master_i) begin
                if (tmr_q.cnt == CNT_LAST) begin
                    tmr_d.cnt   = '0;
                    tmr_d.pulse = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end else begin
                tmr_d.pulse = load_i & ~tmr_q.load_prev;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = tmr_q.pulse;
    assign load_o = tmr_q.pulse & is_master_i;

endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch #(
    parameter int NUM_PINS   = 80,
    parameter int ROW_STRIDE = 32,
    parameter int ADDR_W     = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [ROW_W:0]         ncom_i,
    output logic                   ram_rd_o,
    output logic [ADDR_W-1:0]      ram_addr_o,
    input  logic [3:0]             ram_data_i,
    output logic [ROW_W-1:0]       row_o,
    output logic                   neg_o,
    output logic [NUM_PINS-1:0]    seg_o
);
    localparam int NIBBLES = NUM_PINS / 4;
    localparam int ROW_W   = $clog2(NUM_PINS);
    localparam int NIB_W   = $clog2(NIBBLES);
    localparam logic [NIB_W-1:0] NIB_LAST = NIB_W'(NIBBLES - 1);

    typedef struct packed {
        logic [ROW_W-1:0]    row;
        logic                neg;
        logic [NIB_W-1:0]    nib;
        logic                busy;
        logic                pend;
        logic [NIB_W-1:0]    pend_nib;
        logic [NUM_PINS-1:0] shadow;
    } fch_t;

    fch_t fch_d, fch_q;

    always_comb begin
        fch_d          = fch_q;
        fch_d.pend     = fch_q.busy;
        fch_d.pend_nib = fch_q.nib;
        if (fch_q.pend)
            fch_d.shadow[int'(fch_q.pend_nib)*4 +: 4] = ram_data_i;
        if (fch_q.busy) begin
            if (fch_q.nib == NIB_LAST) fch_d.busy = 1'b0;
            else                       fch_d.nib  = fch_q.nib + 1'b1;
        end
        if (tick_i) begin
            if ({1'b0, fch_q.row} >= ncom_i - 1'b1) begin
                fch_d.row = '0;
                fch_d.neg = ~fch_q.neg;
            end else begin
                fch_d.row = fch_q.row + 1'b1;
            end
            fch_d.nib  = '0;
            fch_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fch_q      <= '0;
            fch_q.busy <= 1'b1;
        end else begin
            fch_q <= fch_d;
        end
    end

    assign ram_rd_o   = fch_q.busy;
    assign ram_addr_o = ADDR_W'(ADDR_W'(fch_q.row) * ADDR_W'(ROW_STRIDE) + ADDR_W'(fch_q.nib));
    assign row_o      = fch_q.row;
    assign neg_o      = fch_q.neg;
    assign seg_o      = fch_q.shadow;

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_scan_pkg::*;
#(
    parameter int NPINS = 80
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   is_master_i,
    input  logic [1:0]             mode_i,
    input  logic [ROW_W-1:0]       row_i,
    input  logic                   neg_i,
    input  logic [NPINS-1:0]       seg_i,
    output logic [NPINS*LVL_W-1:0] level_o,
    output logic                   frame_neg_o
);
    localparam int ROW_W = $clog2(NPINS);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             neg;
        logic [NPINS-1:0] seg;
    } disp_t;

    disp_t disp_d, disp_q;
    int    nseg;

    always_comb begin
        disp_d = disp_q;
        if (tick_i) begin
            disp_d.row = row_i;
            disp_d.neg = neg_i;
            disp_d.seg = seg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    always_comb nseg = seg_pins(is_master_i, mode_i);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        lvl_e code;
        always_comb begin
            if (is_master_i && p >= nseg) begin
                if ((p - nseg) == int'(disp_q.row))
                    code = disp_q.neg ? LV_GND : LV_V1;
                else
                    code = disp_q.neg ? LV_V2 : LV_V5;
            end else if (disp_q.seg[p]) begin
                code = disp_q.neg ? LV_V1 : LV_GND;
            end else begin
                code = disp_q.neg ? LV_V4 : LV_V3;
            end
        end
        assign level_o[p*LVL_W +: LVL_W] = code;
    end

    assign frame_neg_o = disp_q.neg;

endmodule

// File: rtl/lcd_scan_sequencer.sv
module lcd_scan_sequencer
    import lcd_scan_pkg::*;
#(
    parameter int ROW_PERIOD = 32,
    parameter int ROW_STRIDE = 32,
    parameter int ADDR_W     = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      standby_i,
    input  logic                      is_master_i,
    input  logic [1:0]                mode_i,
    input  logic                      load_i,
    output logic                      load_o,
    output logic                      ram_rd_o,
    output logic [ADDR_W-1:0]         ram_addr_o,
    input  logic [3:0]                ram_data_i,
    output logic [NUM_PINS*LVL_W-1:0] level_o,
    output logic                      frame_neg_o,
    output logic [1:0]                bias_o
);
    localparam int ROW_W = $clog2(NUM_PINS);

    logic                row_tick;
    logic [ROW_W:0]      ncom;
    logic [ROW_W-1:0]    fetch_row;
    logic                fetch_neg;
    logic [NUM_PINS-1:0] fetch_seg;

    assign ncom   = (ROW_W+1)'(com_rows(mode_i));
    assign bias_o = bias_of(mode_i);

    lcd_row_timer #(.ROW_PERIOD(ROW_PERIOD)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .is_master_i (is_master_i),
        .load_i      (load_i),
        .tick_o      (row_tick),
        .load_o      (load_o)
    );

    lcd_row_fetch #(
        .NUM_PINS   (NUM_PINS),
        .ROW_STRIDE (ROW_STRIDE),
        .ADDR_W     (ADDR_W)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (row_tick),
        .ncom_i     (ncom),
        .ram_rd_o   (ram_rd_o),
        .ram_addr_o (ram_addr_o),
        .ram_data_i (ram_data_i),
        .row_o      (fetch_row),
        .neg_o      (fetch_neg),
        .seg_o      (fetch_seg)
    );

    lcd_level_map #(.NPINS(NUM_PINS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (row_tick),
        .is_master_i (is_master_i),
        .mode_i      (mode_i),
        .row_i       (fetch_row),
        .neg_i       (fetch_neg),
        .seg_i       (fetch_seg),
        .level_o     (level_o),
        .frame_neg_o (frame_neg_o)
    );

endmodule

// File: rtl/lcd_scan_sequencer_chk.sv
module lcd_scan_sequencer_chk #(
    parameter int ADDR_W = 12,
    parameter int LV_W   = 240
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic              is_master_i,
    input logic [1:0]        mode_i,
    input logic              load_o,
    input logic              ram_rd_o,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic [LV_W-1:0]   level_o,
    input logic              frame_neg_o,
    input logic [1:0]        bias_o,
    input logic              row_tick
);
    a_r10_standby_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !load_o);

    a_r3_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    a_r5_nibble_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_o |-> (ram_addr_o[4:0] < 5'd20));

    a_r8_frame_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_neg_o) |-> $past(row_tick));

    a_r9_levels_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(mode_i) && $stable(is_master_i) && !$past(row_tick)) |-> $stable(level_o));

    a_r2_bias_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bias_o != 2'd3);
endmodule

bind lcd_scan_sequencer lcd_scan_sequencer_chk #(.ADDR_W(ADDR_W), .LV_W(240)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby_i),
    .is_master_i (is_master_i),
    .mode_i      (mode_i),
    .load_o      (load_o),
    .ram_rd_o    (ram_rd_o),
    .ram_addr_o  (ram_addr_o),
    .level_o     (level_o),
    .frame_neg_o (frame_neg_o),
    .bias_o      (bias_o),
    .row_tick    (row_tick)
);

// File: tb/tb_lcd_scan_sequencer.sv
`timescale 1ns/1ps
module tb_lcd_scan_sequencer;
    localparam int PER = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         standby_i = 1'b0;
    logic         is_master_i = 1'b1;
    logic [1:0]   mode_i = 2'd0;
    logic         load_i = 1'b0;
    logic         load_o;
    logic         ram_rd_o;
    logic [11:0]  ram_addr_o;
    logic [3:0]   ram_data_i = 4'd0;
    logic [239:0] level_o;
    logic         frame_neg_o;
    logic [1:0]   bias_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lcd_scan_sequencer dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .is_master_i(is_master_i),
        .mode_i(mode_i), .load_i(load_i), .load_o(load_o), .ram_rd_o(ram_rd_o),
        .ram_addr_o(ram_addr_o), .ram_data_i(ram_data_i), .level_o(level_o),
        .frame_neg_o(frame_neg_o), .bias_o(bias_o)
    );

    function automatic logic [3:0] ram_f(int a);
        return 4'((a * 13) ^ (a >> 5) ^ 9);
    endfunction

    always @(posedge clk) if (ram_rd_o) ram_data_i <= ram_f(int'(ram_addr_o));

    function automatic logic [79:0] row_bits(int r);
        logic [79:0] v;
        for (int s = 0; s < 80; s++) v[s] = ram_f(r * 32 + s / 4) >> (s % 4);
        return v;
    endfunction

    function automatic int nseg_of(bit m, logic [1:0] md);
        if (!m) return 80;
        case (md) 2'd0: return 16; 2'd1: return 0; 2'd2: return 32; default: return 48; endcase
    endfunction

    function automatic int ncom_of(logic [1:0] md);
        case (md) 2'd0: return 64; 2'd1: return 80; 2'd2: return 48; default: return 32; endcase
    endfunction

    function automatic logic [239:0] exp_lv(bit m, logic [1:0] md, int row, bit neg, logic [79:0] seg);
        logic [239:0] v;
        int ns = nseg_of(m, md);
        for (int p = 0; p < 80; p++) begin
            logic [2:0] c;
            if (m && p >= ns) c = ((p - ns) == row) ? (neg ? 3'd5 : 3'd0) : (neg ? 3'd1 : 3'd4);
            else              c = seg[p] ? (neg ? 3'd0 : 3'd5) : (neg ? 3'd3 : 3'd2);
            v[p*3 +: 3] = c;
        end
        return v;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(bit m, logic [1:0] md);
        @(negedge clk);
        rst_n = 1'b0; is_master_i = m; mode_i = md; standby_i = 1'b0; load_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_load(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!load_o && n < 1000);
    endtask

    // R1, R2: reset state and pin split / bias for every role and mode
    task automatic t_reset_modes();
        for (int m = 1; m >= 0; m--) begin
            for (int md = 0; md < 4; md++) begin
                do_reset(bit'(m), 2'(md));
                @(negedge clk);
                chk(level_o == exp_lv(bit'(m), 2'(md), 0, 0, '0), (m && md == 0) ? "R1" : "R2",
                    "reset levels", 256'(level_o), 256'(exp_lv(bit'(m), 2'(md), 0, 0, '0)));
                chk(bias_o == ((md == 3) ? 2'd0 : (md == 2) ? 2'd1 : 2'd2), "R2", "bias",
                    256'(bias_o), 256'((md == 3) ? 0 : (md == 2) ? 1 : 2));
            end
        end
        do_reset(1'b1, 2'd0);
        @(negedge clk);
        chk(!load_o && !frame_neg_o, "R1", "load/frame after reset", 256'({load_o, frame_neg_o}), 256'(0));
    endtask

    // R3: strobe period and width
    task automatic t_load_period();
        int n;
        do_reset(1'b1, 2'd3);
        wait_load(n);
        wait_load(n);
        chk(n == PER, "R3", "strobe period", 256'(n), 256'(PER));
        @(negedge clk);
        chk(!load_o, "R3", "strobe width", 256'(load_o), 256'(0));
    endtask

    // R5..R9: master scan over more than one frame
    task automatic t_master_scan(logic [1:0] md, int nticks);
        int n;
        logic [239:0] prev, e;
        int nc = ncom_of(md);
        do_reset(1'b1, md);
        prev = exp_lv(1'b1, md, 0, 0, '0);
        for (int k = 1; k <= nticks; k++) begin
            int r = (k - 1) % nc;
            bit ng = bit'(((k - 1) / nc) % 2);
            wait_load(n);
            chk(level_o == prev, "R9", "levels during strobe", 256'(level_o), 256'(prev));
            @(negedge clk);
            e = exp_lv(1'b1, md, r, ng, row_bits(r));
            chk(level_o == e, ng ? "R5 R7" : "R5 R6", "row levels", 256'(level_o), 256'(e));
            chk(frame_neg_o == ng, "R8", "frame polarity", 256'(frame_neg_o), 256'(ng));
            prev = e;
        end
    endtask

    // R4: slave follows load_i edges only
    task automatic t_slave();
        int hi = 0;
        logic [239:0] e;
        do_reset(1'b0, 2'd2);
        repeat (40) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            load_i = 1'b1;
            for (int c = 0; c < 6; c++) begin @(negedge clk); if (load_o) hi++; end
            load_i = 1'b0;
            for (int c = 0; c < 34; c++) begin @(negedge clk); if (load_o) hi++; end
            e = exp_lv(1'b0, 2'd2, k, 0, row_bits(k));
            chk(level_o == e, "R4", "slave row levels", 256'(level_o), 256'(e));
        end
        chk(hi == 0, "R4", "slave load_o quiet", 256'(hi), 256'(0));
    endtask

    // R10: standby freezes scan
    task automatic t_standby();
        int n, hi = 0;
        logic [239:0] snap, e;
        do_reset(1'b1, 2'd3);
        wait_load(n); wait_load(n); wait_load(n);
        @(negedge clk);
        snap = level_o;
        standby_i = 1'b1;
        for (int c = 0; c < 100; c++) begin @(negedge clk); if (load_o) hi++; end
        chk(hi == 0, "R10", "no strobe in standby", 256'(hi), 256'(0));
        chk(level_o == snap, "R10", "levels frozen", 256'(level_o), 256'(snap));
        standby_i = 1'b0;
        wait_load(n);
        chk(n <= PER, "R10", "resume delay", 256'(n), 256'(PER));
        @(negedge clk);
        e = exp_lv(1'b1, 2'd3, 3, 0, row_bits(3));
        chk(level_o == e, "R10", "row after resume", 256'(level_o), 256'(e));
    endtask

    initial begin
        t_reset_modes();
        t_load_period();
        t_master_scan(2'd3, 34);
        t_master_scan(2'd2, 5);
        t_master_scan(2'd0, 3);
        t_slave();
        t_standby();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule